// File: doc/BRIEF.md
# Configuration Request Packer

This block takes one configuration-space access at a time (target bus, device/function, byte address, access size and, for writes, data) and emits it as a configuration request packet over a 64-bit transmit port. Each beat carries two 32-bit words. The first beat is flagged as start and the last beat as end. From the access the block derives the byte-enable mask, the data lane shift and the Type 0 or Type 1 format. It builds the three header words and picks two-beat or three-beat packing from the address alignment.

The block keeps the bus number of the root port. Requests aimed at that bus are sent as Type 0 and all others as Type 1. A write that lands on the primary-bus-number register of the root port loads a new root bus number. The block refuses two kinds of access without sending anything: an access to the root port's own first base address register, and an access to any device number other than 0 on the root bus or on the bus directly below it. Every accepted request gets a one-cycle response with a status code.

Top module: `cfg_tlp_packer`

## Requirements
- R1: After reset the stored root bus number is 0, `tx_valid` and `resp_valid` are low and `req_ready` is high.
- R2: The format/type byte is 0x04 for a read and 0x44 for a write when `req_bus` equals the root bus number. For any other bus it is 0x05 for a read and 0x45 for a write.
- R3: Header word 0 carries the format/type byte in bits 31:24 and the value 1 (a one-word length) in bits 23:0.
- R4: Header word 1 is {root bus number, ROOT_DEVFN, tag, 4'b0, byte enables} from bit 31 down. The tag is 0x1D for reads and 0x10 for writes.
- R5: Header word 2 is {bus, devfn, 4'b0, address[11:2], 2'b00} from bit 31 down.
- R6: `req_size` 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 selects 4 bytes. Byte enables are 1<<addr[1:0] for 1 byte, 3<<addr[1:0] for 2 bytes (truncated to 4 bits) and 0xF for 4 bytes. Write data is masked to the access size and then shifted left by 8*addr[1:0]. Reads carry zero data.
- R7: Beat 1 is {word 1, word 0} (word 0 in bits 31:0) with `tx_sop` set and `tx_eop` clear. Reads, and writes with addr[2]=1, end with beat 2 = {data, word 2} with `tx_eop` set.
- R8: A write with addr[2]=0 sends beat 2 as {32'b0, word 2} with neither marker set, then beat 3 as {32'b0, data} with `tx_eop` set.
- R9: An access to the root bus with devfn 0 and address[11:2] equal to HIDE_OFS[11:2] sends nothing and answers status 1.
- R10: If R9 does not apply, an access with devfn[7:3] other than 0 to the root bus or to root bus + 1 (mod 256) sends nothing and answers status 2. All other accesses answer status 0 and are sent.
- R11: An accepted status-0 write to the root bus with address[11:2] equal to PRIBUS_OFS[11:2] loads the root bus number with bits 7:0 of the shifted write data in the same cycle. No other event changes the root bus number.
- R12: `req_ready` is low from the cycle after a request is sent until the cycle after its last beat is taken. A beat stays unchanged while `tx_ready` is low. `resp_valid` pulses for one cycle, in the cycle after every accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The block can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (7:3) and function (2:0) |
| req_addr | input | 12 | Byte address in configuration space |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right-aligned |
| resp_valid | output | 1 | Status of the last accepted request is valid |
| resp_status | output | 2 | 0 sent, 1 bad register, 2 no device |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Sink takes the beat |
| tx_data | output | 64 | Beat payload, two 32-bit words |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| root_bus | output | 8 | Current root bus number |

## Verification
The bench builds the block with ROOT_DEVFN = 0x08 so that the requester ID's low byte differs from its reset-like zero. The other offsets stay at their defaults, 0x10 for the hidden register and 0x18 for the primary bus register. With these values the bench can move the root bus to 0x22 and check that the Type 0/Type 1 choice, the requester ID's upper byte, the hidden-register test and the bus-below test all follow the new number. A pseudo-random `tx_ready` pattern stalls every beat position, including the middle beat of the three-beat form.

// File: rtl/cfg_tlp_packer.sv
module cfg_tlp_packer #(
  parameter logic [7:0]  ROOT_DEVFN = 8'h00,
  parameter logic [11:0] HIDE_OFS   = 12'h010,
  parameter logic [11:0] PRIBUS_OFS = 12'h018
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_bus,
  input  logic [7:0]  req_devfn,
  input  logic [11:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        resp_valid,
  output logic [1:0]  resp_status,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [63:0] tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic [7:0]  root_bus
);

  localparam logic [1:0] ST_OK = 2'd0, ST_BADREG = 2'd1, ST_NODEV = 2'd2;

  logic [7:0]  root_q;
  logic [1:0]  idx_q;
  logic        three_q;
  logic [31:0] dw0_q, dw1_q, dw2_q, dat_q;

  wire accept   = req_valid && req_ready;
  wire on_root  = req_bus == root_q;
  wire below    = req_bus == 8'(root_q + 8'd1);
  wire hide     = on_root && req_devfn == 8'h00 && req_addr[11:2] == HIDE_OFS[11:2];
  wire nodev    = (on_root || below) && req_devfn[7:3] != 5'd0;
  wire [1:0] status = hide ? ST_BADREG : (nodev ? ST_NODEV : ST_OK);

  logic [3:0]  be;
  logic [31:0] wmask;
  always_comb begin
    case (req_size)
      2'd0:    begin be = 4'(4'b0001 << req_addr[1:0]); wmask = {24'h0, req_wdata[7:0]};  end
      2'd1:    begin be = 4'(4'b0011 << req_addr[1:0]); wmask = {16'h0, req_wdata[15:0]}; end
      default: begin be = 4'hF;                         wmask = req_wdata;                end
    endcase
  end

  wire [31:0] shifted = wmask << {req_addr[1:0], 3'b000};
  wire [31:0] payload = req_write ? shifted : 32'h0;
  wire [7:0]  fmt     = {1'b0, req_write, 3'b000, 1'b1, 1'b0, !on_root};
  wire [7:0]  tag     = req_write ? 8'h10 : 8'h1D;
  wire        setroot = accept && status == ST_OK && req_write && on_root &&
                        req_addr[11:2] == PRIBUS_OFS[11:2];

  assign req_ready = idx_q == 2'd0;
  assign tx_valid  = idx_q != 2'd0;
  assign tx_sop    = idx_q == 2'd1;
  assign tx_eop    = (idx_q == 2'd2 && !three_q) || idx_q == 2'd3;
  assign root_bus  = root_q;

  always_comb begin
    case (idx_q)
      2'd1:    tx_data = {dw1_q, dw0_q};
      2'd2:    tx_data = three_q ? {32'h0, dw2_q} : {dat_q, dw2_q};
      2'd3:    tx_data = {32'h0, dat_q};
      default: tx_data = 64'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q      <= 8'h00;
      idx_q       <= 2'd0;
      three_q     <= 1'b0;
      dw0_q       <= 32'h0;
      dw1_q       <= 32'h0;
      dw2_q       <= 32'h0;
      dat_q       <= 32'h0;
      resp_valid  <= 1'b0;
      resp_status <= ST_OK;
    end else begin
      resp_valid <= accept;
      if (accept) begin
        resp_status <= status;
        if (status == ST_OK) begin
          idx_q   <= 2'd1;
          three_q <= req_write && !req_addr[2];
          dw0_q   <= {fmt, 24'h000001};
          dw1_q   <= {root_q, ROOT_DEVFN, tag, 4'h0, be};
          dw2_q   <= {req_bus, req_devfn, 4'h0, req_addr[11:2], 2'b00};
          dat_q   <= payload;
        end
      end else if (tx_valid && tx_ready) begin
        idx_q <= tx_eop ? 2'd0 : 2'(idx_q + 2'd1);
      end
      if (setroot) root_q <= shifted[7:0];
    end
  end

  // R7
  sop_not_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> !tx_eop);

  // R8
  sop_followed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_sop |=> tx_valid && !tx_sop);

  // R12
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_eop) && $stable(tx_sop));

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  // R12
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);

  // R11
  root_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(root_bus));

endmodule

// File: tb/test_cfg_tlp_packer.sv
`timescale 1ns/1ps
module test_cfg_tlp_packer;
  localparam logic [7:0] RDF = 8'h08;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, tx_ready = 1'b0;
  logic [7:0] req_bus = 8'h0, req_devfn = 8'h0;
  logic [11:0] req_addr = 12'h0;
  logic [1:0] req_size = 2'd0;
  logic [31:0] req_wdata = 32'h0;
  logic req_ready, resp_valid, tx_valid, tx_sop, tx_eop;
  logic [1:0] resp_status;
  logic [63:0] tx_data;
  logic [7:0] root_bus;

  always #2.5 clk = ~clk;

  cfg_tlp_packer #(.ROOT_DEVFN(RDF)) i_cfg_tlp_packer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_status(resp_status), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .root_bus(root_bus));

  int checks = 0, errors = 0;
  bit started = 0, done = 0;
  logic [67:0] q[$];
  int mroot = 0;
  bit pend = 0;
  int pstat = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic model_accept();
    int a, sh, be, d, st, fmt, dw0, dw1, dw2;
    bit t1;
    a = int'(req_addr);
    sh = (a % 4) * 8;
    if (req_size == 0)      begin be = (1 << (a % 4)) & 15; d = int'(req_wdata) & 'hFF;   end
    else if (req_size == 1) begin be = (3 << (a % 4)) & 15; d = int'(req_wdata) & 'hFFFF; end
    else                    begin be = 15;                  d = int'(req_wdata);          end
    d = d << sh;
    t1 = int'(req_bus) != mroot;
    if (req_write) fmt = t1 ? 'h45 : 'h44; else fmt = t1 ? 'h05 : 'h04;
    if (!t1 && req_devfn == 0 && (a / 4) == 4) st = 1;
    else if ((!t1 || int'(req_bus) == ((mroot + 1) % 256)) && (req_devfn / 8) != 0) st = 2;
    else st = 0;
    pend = 1;
    pstat = st;
    if (st == 0) begin
      dw0 = (fmt << 24) | 1;
      dw1 = (mroot << 24) | (int'(RDF) << 16) | ((req_write ? 'h10 : 'h1D) << 8) | be;
      dw2 = (int'(req_bus) << 24) | (int'(req_devfn) << 16) | ((a / 4) * 4);
      if (!req_write) d = 0;
      q.push_back({4'd1, 32'(dw1), 32'(dw0)});
      if (req_write && (a % 8) < 4) begin
        q.push_back({4'd3, 32'h0, 32'(dw2)});
        q.push_back({4'd4, 32'h0, 32'(d)});
      end else begin
        q.push_back({4'd2, 32'(d), 32'(dw2)});
      end
      if (req_write && !t1 && (a / 4) == 6) mroot = d & 'hFF;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && started) begin
      logic [67:0] e;
      int k;
      check(req_ready == (q.size() == 0), "R12 req_ready", req_ready, q.size() == 0);
      check(tx_valid == (q.size() != 0), "R12 tx_valid", tx_valid, q.size() != 0);
      check(resp_valid == pend, "R12 resp_valid", resp_valid, pend);
      if (pend && resp_valid) begin
        if (pstat == 1) check(resp_status == 1, "R9 status", resp_status, 1);
        else            check(resp_status == 2'(pstat), "R10 status", resp_status, pstat);
      end
      check(root_bus == 8'(mroot), "R11 root bus", root_bus, mroot);
      if (q.size() != 0 && tx_valid) begin
        e = q[0];
        k = int'(e[67:64]);
        check(tx_sop == (k == 1), "R7 sop marker", tx_sop, k == 1);
        check(tx_eop == (k == 2 || k == 4), "R8 eop marker", tx_eop, k == 2 || k == 4);
        case (k)
          1: begin
            check(tx_data[31:24] == e[31:24], "R2 format/type", tx_data[31:24], e[31:24]);
            check(tx_data[23:0] == 24'h1, "R3 length field", tx_data[23:0], 1);
            check(tx_data[63:32] == e[63:32], "R4 header word 1", tx_data[63:32], e[63:32]);
          end
          2: begin
            check(tx_data[31:0] == e[31:0], "R5 header word 2", tx_data[31:0], e[31:0]);
            check(tx_data[63:32] == e[63:32], "R6 data lane", tx_data[63:32], e[63:32]);
          end
          3: begin
            check(tx_data[31:0] == e[31:0], "R5 header word 2", tx_data[31:0], e[31:0]);
            check(tx_data[63:32] == 32'h0, "R8 upper half zero", tx_data[63:32], 0);
          end
          default: check(tx_data == e[63:0], "R8 data beat R6", tx_data, e[63:0]);
        endcase
        if (tx_ready) void'(q.pop_front());
      end
      pend = 0;
      if (req_valid && req_ready) model_accept();
    end
  end

  initial begin
    logic [7:0] lf = 8'h5B;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tx_ready = lf[0] | lf[2];
    end
  end

  task automatic do_req(input bit w, input logic [7:0] b, input logic [7:0] df,
                        input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_bus = b; req_devfn = df;
    req_addr = a; req_size = sz; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (14) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(root_bus == 8'h0, "R1 root bus", root_bus, 0);
    check(!tx_valid, "R1 tx_valid", tx_valid, 0);
    check(!resp_valid, "R1 resp_valid", resp_valid, 0);
    check(req_ready, "R1 req_ready", req_ready, 1);
    started = 1;
    do_req(0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0);          // R2 Type 0 read
    do_req(0, 8'h05, 8'h28, 12'h00E, 2'd1, 32'h0);          // R6 2-byte read, Type 1
    do_req(1, 8'h03, 8'h00, 12'h020, 2'd2, 32'hCAFE_F00D);  // R8 aligned write
    do_req(1, 8'h03, 8'h11, 12'h025, 2'd0, 32'h1234_56A7);  // R7 unaligned byte write
    do_req(1, 8'h07, 8'h02, 12'h00B, 2'd1, 32'hFFFF_BEEF);  // R6 2-byte at byte 3
    do_req(0, 8'h00, 8'h00, 12'h013, 2'd0, 32'h0);          // R9 hidden register
    do_req(1, 8'h00, 8'h00, 12'h010, 2'd2, 32'h5);          // R9 hidden write
    do_req(0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0);          // R10 root bus dev 1
    do_req(0, 8'h01, 8'h10, 12'h000, 2'd2, 32'h0);          // R10 bus below dev 2
    do_req(0, 8'h01, 8'h01, 12'h004, 2'd2, 32'h0);          // R10 bus below dev 0 fn 1
    do_req(1, 8'h00, 8'h00, 12'h018, 2'd0, 32'hAB22);       // R11 new root bus 0x22
    do_req(0, 8'h22, 8'h00, 12'h040, 2'd2, 32'h0);          // R2 Type 0 on new root
    do_req(0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0);          // R9 old root no longer hidden
    do_req(0, 8'h23, 8'h18, 12'h000, 2'd2, 32'h0);          // R10 below new root
    do_req(1, 8'h22, 8'h00, 12'h010, 2'd3, 32'h1);          // R9 hidden on new root
    do_req(1, 8'h22, 8'h00, 12'h01C, 2'd2, 32'h77);         // R11 other offset, no change
    do_req(1, 8'h40, 8'h31, 12'hFF8, 2'd2, 32'h8765_4321);  // R5 top of space
    repeat (5) @(posedge clk);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end
endmodule